// File: doc/BRIEF.md
# Ethernet Pause Flow Control Timers

This block keeps the two timers behind pause-based flow control on one Ethernet port. On the transmit side, a received pause frame (already decoded elsewhere) arrives as a one-cycle strobe carrying its quanta. In full-duplex mode with transmit flow control enabled, the strobe loads a 16-bit hold-off timer. That timer counts down once per slot-time tick. While it is nonzero, new data frames are held back. A frame that is already being sent when the pause lands is let through, and the hold takes effect from the next idle point of the transmitter.

On the receive side, a congestion trigger from the buffer logic makes the block ask an external frame generator for an outgoing pause frame that advertises the maximum pause time. The request is a valid/ready channel. Valid rises on its own and is then held until the generator takes it with ready; ready may stay low for any number of cycles, and nothing is lost or repeated while it does. Acceptance loads a re-pause timer with a value a little below the advertised time, so a fresh pause goes out before the partner's copy runs out, for as long as the trigger stays high. In half-duplex mode the block raises a collision-force request instead of asking for pause frames.

A test port can write either timer directly, but only while test mode is on.

Top module: `pause_flow_ctl`

## Requirements
- R1: When `rx_pause_valid` is high with `full_duplex`=1 and `tx_flow_en`=1, the transmit timer loads `rx_pause_quanta` at that edge. It then drops by one on every edge where `slot_tick`=1 until it reaches zero. `tx_flow_active` is high exactly while the timer is nonzero, so a quanta of Q keeps it high for Q ticks.
- R2: A pause strobe is ignored when `full_duplex`=0 or `tx_flow_en`=0. The transmit timer, and so `tx_flow_active`, is left unchanged.
- R3: `tx_hold` is high only while `tx_flow_active` is high. If `tx_idle`=0 when the pause begins, `tx_hold` stays low until the first cycle with `tx_idle`=1. From then on it stays high until the timer expires.
- R4: With `full_duplex`=1, `rx_flow_en`=1 and `cong_trig`=1, a zero receive timer raises `pause_req_valid` on the next edge. `pause_req_time` is always PAUSE_TIME (default 0xFFFF).
- R5: Once `pause_req_valid` is high, it stays high until a cycle with `pause_req_ready`=1. That handshake loads the receive timer with RX_RELOAD (default 0xFF00) if the trigger condition of R4 still holds. `tx_hold` never gates the request.
- R6: The receive timer drops by one per `slot_tick`. When it reaches zero with the R4 condition still true, a new request is raised.
- R7: Whenever the R4 condition is false (trigger low, half duplex, or receive flow disabled), the receive timer is cleared to zero and no new request is raised.
- R8: `coll_force` = `rx_flow_en` & `cong_trig` & !`full_duplex`. No pause request is started in half-duplex mode.
- R9: `rx_flow_active` = `rx_flow_en` & `cong_trig`.
- R10: With `test_mode`=1 and `tst_wr_en`=1, `tst_wr_data` is written at the next edge into the transmit timer (`tst_wr_sel`=0) or the receive timer (`tst_wr_sel`=1). This write takes priority over every other update. With `test_mode`=0 the write is ignored.
- R11: After reset both timers are zero, and `pause_req_valid`, `tx_flow_active`, `tx_hold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| full_duplex | input | 1 | 1 = full-duplex link |
| tx_flow_en | input | 1 | Act on received pause frames |
| rx_flow_en | input | 1 | Generate flow control on congestion |
| rx_pause_valid | input | 1 | Received pause frame strobe |
| rx_pause_quanta | input | TIMER_W | Pause time of the received frame |
| cong_trig | input | 1 | Receive congestion trigger |
| tx_idle | input | 1 | Transmitter is between frames |
| test_mode | input | 1 | Enables direct timer writes |
| tst_wr_en | input | 1 | Timer write strobe |
| tst_wr_sel | input | 1 | 0 = transmit timer, 1 = receive timer |
| tst_wr_data | input | TIMER_W | Timer write value |
| pause_req_ready | input | 1 | Frame generator accepts the request |
| pause_req_valid | output | 1 | Outgoing pause frame request |
| pause_req_time | output | TIMER_W | Pause time to advertise |
| tx_hold | output | 1 | Block start of new data frames |
| coll_force | output | 1 | Force collisions (half duplex) |
| tx_flow_active | output | 1 | Transmit pause being observed |
| rx_flow_active | output | 1 | Receive flow control triggered |

## Verification
A wrong transmit timer count appears at the ports on the exact slot tick where `tx_flow_active` falls, one tick early or late. A wrong receive timer shows as a pause request that comes too early or too late, or not at all. That is seen at the expiry tick, or at the very next edge after the trigger drops or a handshake completes. The bench keeps an independent cycle model of both timers and compares every output in every cycle. Any divergence is therefore caught in the cycle where it first reaches a port, not at the end of a long pause.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned TIMER_W_DEF = 16;
  typedef enum logic { SEL_TX = 1'b0, SEL_RX = 1'b1 } tmr_sel_e;
endpackage

// File: rtl/pfc_tx_timer.sv
module pfc_tx_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_tick,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         tx_idle,
  output logic [W-1:0] cnt,
  output logic         active,
  output logic         hold
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic armed;

  assign active = (cnt != ZERO);
  assign hold   = active & (armed | tx_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
    end else if (wr_en) begin
      cnt <= wr_val;
    end else if (load_en) begin
      cnt <= load_val;
    end else if (slot_tick && active) begin
      cnt <= cnt - ONE;
    end
  end

  // A frame in flight finishes; the hold latches at the first idle point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= active & (armed | tx_idle);
  end
endmodule

// File: rtl/pfc_rx_timer.sv
module pfc_rx_timer #(
  parameter int unsigned   W      = 16,
  parameter logic [W-1:0]  RELOAD = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_tick,
  input  logic         trig_eff,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         req_ready,
  output logic [W-1:0] cnt,
  output logic         req_valid
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic hs;
  assign hs = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
    end else if (hs) begin
      req_valid <= 1'b0;
    end else if (trig_eff && cnt == ZERO) begin
      req_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
    end else if (wr_en) begin
      cnt <= wr_val;
    end else if (!trig_eff) begin
      cnt <= ZERO;
    end else if (hs) begin
      cnt <= RELOAD;
    end else if (slot_tick && cnt != ZERO) begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl
  import pfc_pkg::*;
#(
  parameter int unsigned         TIMER_W    = TIMER_W_DEF,
  parameter logic [TIMER_W-1:0]  RX_RELOAD  = 16'hFF00,
  parameter logic [TIMER_W-1:0]  PAUSE_TIME = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_tick,
  input  logic               full_duplex,
  input  logic               tx_flow_en,
  input  logic               rx_flow_en,
  input  logic               rx_pause_valid,
  input  logic [TIMER_W-1:0] rx_pause_quanta,
  input  logic               cong_trig,
  input  logic               tx_idle,
  input  logic               test_mode,
  input  logic               tst_wr_en,
  input  logic               tst_wr_sel,
  input  logic [TIMER_W-1:0] tst_wr_data,
  input  logic               pause_req_ready,
  output logic               pause_req_valid,
  output logic [TIMER_W-1:0] pause_req_time,
  output logic               tx_hold,
  output logic               coll_force,
  output logic               tx_flow_active,
  output logic               rx_flow_active
);
  logic               pause_take;
  logic               wr_tx, wr_rx;
  logic               rx_eff;
  logic [TIMER_W-1:0] tx_cnt, rx_cnt;

  assign pause_take = rx_pause_valid & full_duplex & tx_flow_en;
  assign wr_tx      = test_mode & tst_wr_en & (tmr_sel_e'(tst_wr_sel) == SEL_TX);
  assign wr_rx      = test_mode & tst_wr_en & (tmr_sel_e'(tst_wr_sel) == SEL_RX);
  assign rx_eff     = full_duplex & rx_flow_en & cong_trig;

  assign coll_force     = ~full_duplex & rx_flow_en & cong_trig;
  assign rx_flow_active = rx_flow_en & cong_trig;
  assign pause_req_time = PAUSE_TIME;

  pfc_tx_timer #(.W(TIMER_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_tick(slot_tick),
    .load_en  (pause_take),
    .load_val (rx_pause_quanta),
    .wr_en    (wr_tx),
    .wr_val   (tst_wr_data),
    .tx_idle  (tx_idle),
    .cnt      (tx_cnt),
    .active   (tx_flow_active),
    .hold     (tx_hold)
  );

  pfc_rx_timer #(.W(TIMER_W), .RELOAD(RX_RELOAD)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_tick(slot_tick),
    .trig_eff (rx_eff),
    .wr_en    (wr_rx),
    .wr_val   (tst_wr_data),
    .req_ready(pause_req_ready),
    .cnt      (rx_cnt),
    .req_valid(pause_req_valid)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         slot_tick,
  input logic         full_duplex,
  input logic         tx_flow_en,
  input logic         rx_flow_en,
  input logic         rx_pause_valid,
  input logic [W-1:0] rx_pause_quanta,
  input logic         cong_trig,
  input logic         test_mode,
  input logic         tst_wr_en,
  input logic         pause_req_valid,
  input logic         pause_req_ready,
  input logic         tx_hold,
  input logic         coll_force,
  input logic         tx_flow_active,
  input logic [W-1:0] tx_cnt,
  input logic [W-1:0] rx_cnt
);
  logic twr;
  assign twr = test_mode & tst_wr_en;

  assert_tx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_valid && full_duplex && tx_flow_en && !twr) |=> tx_cnt == $past(rx_pause_quanta));

  assert_tx_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && tx_cnt != '0 && !rx_pause_valid && !twr) |=> tx_cnt == $past(tx_cnt) - W'(1));

  assert_half_duplex_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_valid && !full_duplex && !twr && !slot_tick) |=> $stable(tx_cnt));

  assert_hold_needs_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> tx_flow_active);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req_valid && !pause_req_ready) |=> pause_req_valid);

  assert_clear_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cong_trig && !twr) |=> rx_cnt == '0);

  assert_no_coll_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> !coll_force);

  assert_no_req_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && !pause_req_valid) |=> !pause_req_valid);
endmodule

bind pause_flow_ctl pfc_checker #(.W(TIMER_W)) u_pfc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .slot_tick      (slot_tick),
  .full_duplex    (full_duplex),
  .tx_flow_en     (tx_flow_en),
  .rx_flow_en     (rx_flow_en),
  .rx_pause_valid (rx_pause_valid),
  .rx_pause_quanta(rx_pause_quanta),
  .cong_trig      (cong_trig),
  .test_mode      (test_mode),
  .tst_wr_en      (tst_wr_en),
  .pause_req_valid(pause_req_valid),
  .pause_req_ready(pause_req_ready),
  .tx_hold        (tx_hold),
  .coll_force     (coll_force),
  .tx_flow_active (tx_flow_active),
  .tx_cnt         (tx_cnt),
  .rx_cnt         (rx_cnt)
);

// File: tb/pause_flow_ctl_bench.sv
`timescale 1ns/1ps
module pause_flow_ctl_bench;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] RLD = 16'h0030;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_tick = 0, full_duplex = 0, tx_flow_en = 0, rx_flow_en = 0;
  logic rx_pause_valid = 0, cong_trig = 0, tx_idle = 1, test_mode = 0;
  logic tst_wr_en = 0, tst_wr_sel = 0, pause_req_ready = 0;
  logic [W-1:0] rx_pause_quanta = '0, tst_wr_data = '0;
  logic pause_req_valid, tx_hold, coll_force, tx_flow_active, rx_flow_active;
  logic [W-1:0] pause_req_time;

  int checks = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pause_flow_ctl #(.TIMER_W(W), .RX_RELOAD(RLD), .PAUSE_TIME(16'hFFFF)) u_pause_flow_ctl (
    .clk, .rst_n, .slot_tick, .full_duplex, .tx_flow_en, .rx_flow_en,
    .rx_pause_valid, .rx_pause_quanta, .cong_trig, .tx_idle, .test_mode,
    .tst_wr_en, .tst_wr_sel, .tst_wr_data, .pause_req_ready,
    .pause_req_valid, .pause_req_time, .tx_hold, .coll_force,
    .tx_flow_active, .rx_flow_active
  );

  // Reference model built from the requirements
  logic [W-1:0] m_tx = '0, m_rx = '0;
  logic m_arm = 0, m_req = 0;

  function automatic logic [W-1:0] nxt_tx(logic [W-1:0] c);
    if (test_mode && tst_wr_en && !tst_wr_sel) return tst_wr_data;          // R10
    if (rx_pause_valid && full_duplex && tx_flow_en) return rx_pause_quanta; // R1/R2
    if (slot_tick && c != 0) return c - 1;
    return c;
  endfunction

  function automatic logic [W-1:0] nxt_rx(logic [W-1:0] c, logic req);
    logic eff = full_duplex & rx_flow_en & cong_trig;
    if (test_mode && tst_wr_en && tst_wr_sel) return tst_wr_data;           // R10
    if (!eff) return '0;                                                      // R7
    if (req && pause_req_ready) return RLD;                                   // R5
    if (slot_tick && c != 0) return c - 1;                                    // R6
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx <= '0; m_rx <= '0; m_arm <= 0; m_req <= 0;
    end else begin
      m_arm <= (m_tx != 0) & (m_arm | tx_idle);
      m_tx  <= nxt_tx(m_tx);
      m_rx  <= nxt_rx(m_rx, m_req);
      if (m_req && pause_req_ready) m_req <= 0;
      else if (full_duplex && rx_flow_en && cong_trig && m_rx == 0) m_req <= 1; // R4/R6
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on && rst_n) begin
    logic e_act, e_hold;
    e_act  = (m_tx != 0);
    e_hold = e_act & (m_arm | tx_idle);
    chk(tx_flow_active == e_act, "R1 tx_flow_active", tx_flow_active, e_act);
    chk(tx_hold == e_hold, "R3 tx_hold", tx_hold, e_hold);
    chk(pause_req_valid == m_req, "R4 pause_req_valid", pause_req_valid, m_req);
    chk(pause_req_time == 16'hFFFF, "R4 pause_req_time", pause_req_time, 16'hFFFF);
    chk(coll_force == (rx_flow_en & cong_trig & ~full_duplex), "R8 coll_force",
        coll_force, rx_flow_en & cong_trig & ~full_duplex);
    chk(rx_flow_active == (rx_flow_en & cong_trig), "R9 rx_flow_active",
        rx_flow_active, rx_flow_en & cong_trig);
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // drop one-cycle strobes after a cycle
  task automatic clr_strobes();
    rx_pause_valid = 0; tst_wr_en = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    cyc(3);
    // R11: reset state
    chk(!pause_req_valid && !tx_flow_active && !tx_hold, "R11 reset outputs",
        {pause_req_valid, tx_flow_active, tx_hold}, 0);
    rst_n = 1; cmp_on = 1;
    cyc(2);

    // R1: quanta 5, tick every cycle -> active for 5 cycles
    full_duplex = 1; tx_flow_en = 1; slot_tick = 1;
    rx_pause_valid = 1; rx_pause_quanta = 5; cyc(1); clr_strobes();
    n = 0;
    while (tx_flow_active && n < 50) begin n++; cyc(1); end
    chk(n == 5, "R1 pause duration", n, 5);

    // R2: ignored in half duplex and with tx flow disabled
    full_duplex = 0; rx_pause_valid = 1; rx_pause_quanta = 9; cyc(1); clr_strobes();
    chk(!tx_flow_active, "R2 half duplex ignore", tx_flow_active, 0);
    full_duplex = 1; tx_flow_en = 0; rx_pause_valid = 1; cyc(1); clr_strobes();
    chk(!tx_flow_active, "R2 disabled ignore", tx_flow_active, 0);
    tx_flow_en = 1;

    // R3: frame in progress when pause lands
    slot_tick = 0; tx_idle = 0; rx_pause_valid = 1; rx_pause_quanta = 4; cyc(1); clr_strobes();
    #1 chk(tx_flow_active && !tx_hold, "R3 in-flight frame not held", tx_hold, 0);
    cyc(2); tx_idle = 1; cyc(1); tx_idle = 0; #1;
    chk(tx_hold, "R3 hold latched after idle", tx_hold, 1);
    slot_tick = 1; cyc(5); slot_tick = 0; tx_idle = 1;
    chk(!tx_hold && !tx_flow_active, "R3 hold released", tx_hold, 0);

    // R10: test write ignored without test mode, honoured with it
    tst_wr_en = 1; tst_wr_sel = 0; tst_wr_data = 7; cyc(1); clr_strobes();
    chk(!tx_flow_active, "R10 write ignored", tx_flow_active, 0);
    test_mode = 1; tst_wr_en = 1; cyc(1); clr_strobes(); test_mode = 0;
    chk(tx_flow_active, "R10 write tx timer", tx_flow_active, 1);
    slot_tick = 1; cyc(7); slot_tick = 0;
    chk(!tx_flow_active, "R10 written value counts out", tx_flow_active, 0);

    // R4/R5/R6/R7: receive side
    rx_flow_en = 1; cong_trig = 1; cyc(1);
    chk(pause_req_valid, "R4 request raised", pause_req_valid, 1);
    cyc(3);
    chk(pause_req_valid, "R5 held without ready", pause_req_valid, 1);
    pause_req_ready = 1; cyc(1); pause_req_ready = 0; slot_tick = 1;
    n = 0;
    while (!pause_req_valid && n < 200) begin n++; cyc(1); end
    chk(n == RLD + 1, "R6 repeat after reload", n, RLD + 1);
    pause_req_ready = 1; cyc(1); pause_req_ready = 0;
    cong_trig = 0; cyc(RLD + 5);
    chk(!pause_req_valid, "R7 no request after drop", pause_req_valid, 0);

    // R8: half duplex collisions
    full_duplex = 0; cong_trig = 1; cyc(3);
    chk(coll_force && !pause_req_valid, "R8 collision force", coll_force, 1);
    cong_trig = 0; full_duplex = 1; slot_tick = 0;

    // Constrained random phase
    for (int i = 0; i < 6000; i++) begin
      slot_tick       = ($urandom % 3) == 0;
      full_duplex     = ($urandom % 16) != 0;
      if (($urandom % 50) == 0) tx_flow_en = ~tx_flow_en;
      if (($urandom % 60) == 0) rx_flow_en = ~rx_flow_en;
      if (($urandom % 80) == 0) cong_trig  = ~cong_trig;
      tx_idle         = ($urandom % 4) != 0;
      rx_pause_valid  = ($urandom % 40) == 0;
      rx_pause_quanta = W'($urandom % 24);
      pause_req_ready = ($urandom % 2) == 0;
      test_mode       = ($urandom % 20) == 0;
      tst_wr_en       = ($urandom % 10) == 0;
      tst_wr_sel      = $urandom % 2;
      tst_wr_data     = W'($urandom % 20);
      cyc(1);
    end
    test_mode = 0; tst_wr_en = 0; rx_pause_valid = 0;
    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule